// File: doc/BRIEF.md
# Stack Pointer Delta Tracker

This decode-side unit removes the explicit stack-pointer arithmetic that push, pop, call and return would otherwise need. Each of these instructions carries an implied stack-pointer adjustment. The unit does not emit an add micro-op for that adjustment. It folds the adjustment into a signed running offset that it holds locally. Every stack access that passes through gets its address displacement patched with the offset that applies to it, so the uncorrected stack pointer can still be used as the base.

Some instructions need the true stack-pointer value. When one of them arrives and the offset is nonzero, the unit asks for a synchronizing micro-op to be placed ahead of that instruction. The micro-op carries the accumulated offset, and the offset then returns to zero. The same request is forced early when the next adjustment would push the offset out of its signed range.

Branches can store the offset as it stands after them in a small checkpoint table, indexed by a branch tag. A mispredict restores the offset from the table entry of that branch. All outputs are registered and appear one clock after the instruction is presented.

Top module: `sp_delta_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `delta_q` is 0 and `out_valid` and `out_sync` are 0.
- R2: A valid push (`in_class` 1) or call (`in_class` 3) lowers the offset by the operand size. Size code 0 means 2 bytes, code 1 means 4 bytes, and codes 2 and 3 mean 8 bytes. No sync is requested unless R5 or R7 applies.
- R3: A valid pop (`in_class` 2) or return (`in_class` 4) raises the offset by the operand size, using the same size codes.
- R4: `out_disp` is the offset after the decrement for push and call, the offset before the increment for pop and return, and the current offset for every other class (0, 5, 6, 7).
- R5: A valid instruction with `in_sp_explicit` high and a nonzero offset gives `out_sync` high, with `out_sync_delta` equal to the prior offset. The offset is cleared before the instruction's own adjustment is applied.
- R6: With the offset at zero, no sync is requested, whatever the value of `in_sp_explicit`.
- R7: If applying an adjustment would take the offset outside the signed `DELTA_W`-bit range, a sync of the prior offset is issued first, and the adjustment is then applied starting from zero.
- R8: A valid instruction with `in_ckpt` high records its resulting offset at `in_tag`. A `mispredict` restores the offset recorded at `mp_tag`, and any instruction presented in the same cycle is dropped (`out_valid` 0).
- R9: In a cycle with neither `in_valid` nor `mispredict`, the offset is unchanged and `out_valid` is 0 in the next cycle.
- R10: `out_sync` is only ever high together with `out_valid`, and then `out_sync_delta` is nonzero. When `out_valid` is high and `out_sync` is low, `out_sync_delta` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_class | input | 3 | Instruction class: 1 push, 2 pop, 3 call, 4 return, other values are non-stack |
| in_size | input | 2 | Operand size code: 0 = 2 bytes, 1 = 4 bytes, 2 or 3 = 8 bytes |
| in_sp_explicit | input | 1 | The instruction needs the true stack-pointer value |
| in_ckpt | input | 1 | Record the resulting offset for this branch |
| in_tag | input | TAG_W | Checkpoint slot written when `in_ckpt` is high |
| mispredict | input | 1 | Restore the offset from a checkpoint slot |
| mp_tag | input | TAG_W | Checkpoint slot read on a mispredict |
| out_valid | output | 1 | Registered outputs belong to an accepted instruction |
| out_disp | output | DELTA_W | Signed displacement to patch into the stack access |
| out_sync | output | 1 | Insert a sync micro-op ahead of this instruction |
| out_sync_delta | output | DELTA_W | Signed offset carried by the sync micro-op |
| delta_q | output | DELTA_W | Current signed offset |

## Verification
The assertions assume that a mispredict names only a checkpoint slot that has already been written since reset, because the table is not cleared. The stimulus meets this by writing every slot before it issues any random mispredict, and its directed mispredict uses a slot written just before. The step checks on push and pop hold only while the offset stays at least one 8-byte step inside its range. The stimulus walks the offset to both edges on purpose, so the forced-sync path is exercised from both directions.

// File: rtl/sp_delta_pkg.sv
`timescale 1ns/1ps
package sp_delta_pkg;
  typedef enum logic [2:0] {
    OP_OTHER = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4
  } op_class_e;
endpackage

// File: rtl/sp_size_dec.sv
`timescale 1ns/1ps
module sp_size_dec #(
  parameter int DELTA_W = 8
) (
  input  logic [1:0]                size_code,
  output logic signed [DELTA_W-1:0] bytes
);
  always_comb begin
    case (size_code)
      2'd0:    bytes = DELTA_W'(2);
      2'd1:    bytes = DELTA_W'(4);
      default: bytes = DELTA_W'(8);
    endcase
  end
endmodule

// File: rtl/sp_ckpt_ram.sv
`timescale 1ns/1ps
module sp_ckpt_ram #(
  parameter int TAG_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [TAG_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TAG_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << TAG_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sp_delta_next.sv
`timescale 1ns/1ps
module sp_delta_next
  import sp_delta_pkg::*;
#(
  parameter int DELTA_W = 8
) (
  input  logic signed [DELTA_W-1:0] cur,
  input  logic [2:0]                cls,
  input  logic signed [DELTA_W-1:0] bytes,
  input  logic                      sp_explicit,
  output logic signed [DELTA_W-1:0] nxt,
  output logic signed [DELTA_W-1:0] disp,
  output logic                      sync
);
  logic                      is_dn, is_up, ovf;
  logic signed [DELTA_W:0]   cur_w, bytes_w, lo_w, hi_w;
  logic signed [DELTA_W-1:0] base;

  always_comb begin
    is_dn   = (cls == OP_PUSH) || (cls == OP_CALL);
    is_up   = (cls == OP_POP)  || (cls == OP_RET);
    cur_w   = {cur[DELTA_W-1], cur};
    bytes_w = {bytes[DELTA_W-1], bytes};
    lo_w    = cur_w - bytes_w;
    hi_w    = cur_w + bytes_w;
    ovf     = (is_dn && (lo_w[DELTA_W] != lo_w[DELTA_W-1])) ||
              (is_up && (hi_w[DELTA_W] != hi_w[DELTA_W-1]));
    sync    = (cur != '0) && (sp_explicit || ovf);
    base    = sync ? '0 : cur;
    if (is_dn) begin
      nxt  = base - bytes;
      disp = nxt;
    end else if (is_up) begin
      nxt  = base + bytes;
      disp = base;
    end else begin
      nxt  = base;
      disp = base;
    end
  end

  // R6: a zero offset never leads to a sync request
  always_comb begin
    p_zero_no_sync_r6: assert (!(sync && (cur == '0)));
  end
endmodule

// File: rtl/sp_delta_tracker.sv
`timescale 1ns/1ps
module sp_delta_tracker
  import sp_delta_pkg::*;
#(
  parameter int DELTA_W = 8,
  parameter int TAG_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [2:0]                in_class,
  input  logic [1:0]                in_size,
  input  logic                      in_sp_explicit,
  input  logic                      in_ckpt,
  input  logic [TAG_W-1:0]          in_tag,
  input  logic                      mispredict,
  input  logic [TAG_W-1:0]          mp_tag,
  output logic                      out_valid,
  output logic signed [DELTA_W-1:0] out_disp,
  output logic                      out_sync,
  output logic signed [DELTA_W-1:0] out_sync_delta,
  output logic signed [DELTA_W-1:0] delta_q
);
  localparam logic signed [DELTA_W-1:0] MIN_V   = {1'b1, {(DELTA_W-1){1'b0}}};
  localparam logic signed [DELTA_W-1:0] MAX_V   = {1'b0, {(DELTA_W-1){1'b1}}};
  localparam logic signed [DELTA_W-1:0] SAFE_LO = MIN_V + DELTA_W'(8);
  localparam logic signed [DELTA_W-1:0] SAFE_HI = MAX_V - DELTA_W'(8);

  logic signed [DELTA_W-1:0] bytes, nxt, disp;
  logic                      sync;
  logic [DELTA_W-1:0]        ck_rd;
  logic                      accept;

  assign accept = in_valid && !mispredict;

  sp_size_dec #(.DELTA_W(DELTA_W)) u_size (
    .size_code (in_size),
    .bytes     (bytes)
  );

  sp_delta_next #(.DELTA_W(DELTA_W)) u_next (
    .cur         (delta_q),
    .cls         (in_class),
    .bytes       (bytes),
    .sp_explicit (in_sp_explicit),
    .nxt         (nxt),
    .disp        (disp),
    .sync        (sync)
  );

  sp_ckpt_ram #(.TAG_W(TAG_W), .DATA_W(DELTA_W)) u_ckpt (
    .clk   (clk),
    .we    (accept && in_ckpt),
    .waddr (in_tag),
    .wdata (nxt),
    .raddr (mp_tag),
    .rdata (ck_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      delta_q        <= '0;
      out_valid      <= 1'b0;
      out_sync       <= 1'b0;
      out_disp       <= '0;
      out_sync_delta <= '0;
    end else if (mispredict) begin
      delta_q   <= ck_rd;
      out_valid <= 1'b0;
      out_sync  <= 1'b0;
    end else if (in_valid) begin
      delta_q        <= nxt;
      out_valid      <= 1'b1;
      out_disp       <= disp;
      out_sync       <= sync;
      out_sync_delta <= sync ? delta_q : '0;
    end else begin
      out_valid <= 1'b0;
      out_sync  <= 1'b0;
    end
  end

  // R10: sync requests ride only on valid outputs and carry a nonzero offset
  p_sync_carries_r10: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> (out_valid && (out_sync_delta != '0)));

  // R9: idle cycles leave the offset alone
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !mispredict) |=> ($stable(delta_q) && !out_valid));

  // R8: an instruction beside a mispredict is dropped
  p_flush_drop_r8: assert property (@(posedge clk) disable iff (rst)
    mispredict |=> !out_valid);

  // R2: a push or call away from the range edge lowers the offset
  p_push_down_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_sp_explicit && ((in_class == OP_PUSH) || (in_class == OP_CALL))
     && (delta_q >= SAFE_LO)) |=> (delta_q < $past(delta_q)));

  // R3: a pop or return away from the range edge raises the offset
  p_pop_up_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_sp_explicit && ((in_class == OP_POP) || (in_class == OP_RET))
     && (delta_q <= SAFE_HI)) |=> (delta_q > $past(delta_q)));

  // R5: an explicit use with a nonzero offset yields a sync
  p_explicit_sync_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && in_sp_explicit && (delta_q != '0)) |=> (out_sync && (out_sync_delta == $past(delta_q))));

  // R7: an 8-byte push close to the lower edge is preceded by a sync
  p_edge_sync_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && (in_class == OP_PUSH) && (in_size == 2'd2) && (delta_q < SAFE_LO))
    |=> (out_sync && (delta_q == -DELTA_W'(8))));
endmodule

// File: tb/test_sp_delta_tracker.sv
`timescale 1ns/1ps
module test_sp_delta_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] in_class = 3'd0;
  logic [1:0] in_size = 2'd0;
  logic in_sp_explicit = 1'b0;
  logic in_ckpt = 1'b0;
  logic [1:0] in_tag = 2'd0;
  logic mispredict = 1'b0;
  logic [1:0] mp_tag = 2'd0;
  logic out_valid, out_sync;
  logic signed [7:0] out_disp, out_sync_delta, delta_q;

  always #5 clk = ~clk;

  sp_delta_tracker #(.DELTA_W(8), .TAG_W(2)) i_sp_delta_tracker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class), .in_size(in_size),
    .in_sp_explicit(in_sp_explicit), .in_ckpt(in_ckpt), .in_tag(in_tag),
    .mispredict(mispredict), .mp_tag(mp_tag), .out_valid(out_valid), .out_disp(out_disp),
    .out_sync(out_sync), .out_sync_delta(out_sync_delta), .delta_q(delta_q));

  int compared = 0;
  int mismatched = 0;
  int m_d = 0;
  int m_tbl [4] = '{0, 0, 0, 0};
  bit finished = 0;

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, int cls, int sc, bit ex, bit ck, int tg, bit mp, int mt);
    int sz, base, disp, sd;
    bit dn, up, ovf, sy, ev;
    string req;
    @(negedge clk);
    in_valid = v; in_class = 3'(cls); in_size = 2'(sc); in_sp_explicit = ex;
    in_ckpt = ck; in_tag = 2'(tg); mispredict = mp; mp_tag = 2'(mt);
    sz = (sc == 0) ? 2 : (sc == 1) ? 4 : 8;
    dn = (cls == 1) || (cls == 3);
    up = (cls == 2) || (cls == 4);
    ev = 0; sy = 0; sd = 0; disp = 0;
    if (mp) begin
      m_d = m_tbl[mt]; req = "R8";
    end else if (v) begin
      ev = 1;
      ovf = dn ? (m_d - sz < -128) : up ? (m_d + sz > 127) : 0;
      sy = (m_d != 0) && (ex || ovf);
      sd = sy ? m_d : 0;
      base = sy ? 0 : m_d;
      if (dn) begin m_d = base - sz; disp = m_d; end
      else if (up) begin disp = base; m_d = base + sz; end
      else begin disp = base; m_d = base; end
      if (ck) m_tbl[tg] = m_d;
      req = (sy && ovf && !ex) ? "R7" : sy ? "R5" : (ex ? "R6" : (dn ? "R2" : (up ? "R3" : "R4")));
    end else begin
      req = "R9";
    end
    @(negedge clk);
    in_valid = 0; mispredict = 0; in_ckpt = 0;
    check(req, "delta_q", int'(delta_q), m_d);
    check(req, "out_valid", int'(out_valid), int'(ev));
    if (ev) begin
      check("R4", "out_disp", int'(out_disp), disp);
      check(req, "out_sync", int'(out_sync), int'(sy));
      check("R10", "out_sync_delta", int'(out_sync_delta), sd);
    end else begin
      check("R10", "out_sync idle", int'(out_sync), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    check("R1", "delta_q in reset", int'(delta_q), 0);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    rst = 0;
    @(negedge clk);
    check("R1", "delta_q after reset", int'(delta_q), 0);
    check("R1", "out_sync after reset", int'(out_sync), 0);
    // R2 R4: two 4-byte pushes give displacements -4, -8
    step(1, 1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0, 0);
    // R5: explicit use syncs -8
    step(1, 0, 1, 1, 0, 0, 0, 0);
    // R6: explicit again with zero offset
    step(1, 0, 1, 1, 0, 0, 0, 0);
    // R3 R4: pop and return
    step(1, 2, 1, 0, 0, 0, 0, 0);
    step(1, 4, 2, 0, 0, 0, 0, 0);
    // R8: call checkpoints at tag 1, then a push, idle, then mispredict
    step(1, 3, 3, 0, 1, 1, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0); // R9
    step(1, 1, 2, 0, 0, 0, 1, 1);
    // R7: walk down to the lower edge with 8-byte pushes
    for (int i = 0; i < 18; i++) step(1, 1, 2, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0, 0);
    // R7: walk up to the upper edge with 8-byte pops
    for (int i = 0; i < 18; i++) step(1, 2, 3, 0, 0, 0, 0, 0);
    // fill every checkpoint slot, then a mixed stream
    for (int t = 0; t < 4; t++) step(1, 3, 1, 0, 1, t, 0, 0);
    lf = 32'h1234_abcd;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[0] | lf[1], int'(lf[4:2]), int'(lf[6:5]), lf[10:7] == 4'd0,
           lf[11], int'(lf[13:12]), lf[17:14] == 4'd0, int'(lf[19:18]));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule